// File: doc/BRIEF.md
# Two-Level Group Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in and returns a 16-bit sum and a carry-out, all within one combinational path. It has no clock and holds no state. Every bit forms a propagate and a generate term. The operand is cut into four 4-bit groups. A lookahead unit in each group derives that group's internal carries from the generate and propagate terms. A second lookahead unit, with the same form as the group units, works on the four group generate/propagate pairs and forms the carry into every group and the final carry-out. No carry ripples from one bit to the next or from one group to the next.

The block also drives the generate and propagate of the whole 16-bit span on its ports. A wider adder can treat this block as a single group and cascade it under a further lookahead level.

Top module: `cla_adder16`

## Requirements
- R1: `{carry_out, sum}` equals `op_a + op_b + carry_in`, computed as a 17-bit unsigned value, for every input combination.
- R2: `grp_gen` is 1 exactly when `op_a + op_b` (carry_in excluded) is 2^16 or more.
- R3: `grp_prop` is 1 exactly when `op_a + op_b` equals 16'hFFFF, which is the case where every bit position propagates.
- R4: `grp_gen` and `grp_prop` are never 1 at the same time.
- R5: `carry_out` equals `grp_gen OR (grp_prop AND carry_in)`.
- R6: With all operand bits propagating, `carry_out` copies `carry_in`. With carry_in = 1 the sum is 16'h0000; with carry_in = 0 it is 16'hFFFF. The carry crosses all four group boundaries in one evaluation.
- R7: A carry generated in one group reaches the next group boundary (bits 4, 8, 12) and the carry-out. For example, 16'h0FFF + 16'h0001 gives 16'h1000 with carry_out 0.
- R8: Outputs depend only on the present inputs. The same input vector gives the same outputs whatever vector came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | The full span generates a carry |
| grp_prop | output | 1 | The full span propagates a carry |

## Verification
The interesting coincidence happens when a carry generated inside one group and the external carry_in both arrive at a run of propagating groups during the same evaluation. Both must resolve through the second-level unit, and neither may mask the other. The bench sets this up with directed vectors. These combine a generating low group with all-propagate upper groups, in both carry_in states, and include all-ones plus one and alternating-bit patterns. It then judges each output against a 17-bit integer sum computed in the bench, with no lookahead structure in the model. Random vectors are compared on every clock in the same way.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int GRP_W = 4;
    localparam int N_GRP = 4;
    localparam int DATA_W = GRP_W * N_GRP;

    typedef struct packed {
        logic [DATA_W-1:0] prop;
        logic [DATA_W-1:0] gen;
    } bit_terms_t;
endpackage

// File: rtl/cla_pfa_row.sv
module cla_pfa_row #(
    parameter int W = cla_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] sum_o
);
    always_comb begin
        prop_o = a_i ^ b_i;
        gen_o  = a_i & b_i;
    end

    always_comb begin
        sum_o = (a_i ^ b_i) ^ carry_i;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_BIT_EXCL: assert ((prop_o & gen_o) == '0); // R4
        end
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int W = cla_pkg::GRP_W
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         carry_i,
    output logic [W:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    // Each carry is expanded into a flat sum of products over gen/prop and
    // the unit's carry-in, so no term waits on another carry.
    always_comb begin
        logic term;
        logic orsum;
        carry_o[0] = carry_i;
        for (int k = 1; k <= W; k++) begin
            orsum = 1'b0;
            for (int j = 0; j <= k; j++) begin
                term = (j == 0) ? carry_i : gen_i[j-1];
                for (int m = j; m < k; m++) begin
                    term = term & prop_i[m];
                end
                orsum = orsum | term;
            end
            carry_o[k] = orsum;
        end
    end

    always_comb begin
        logic term;
        logic orsum;
        orsum = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = gen_i[j];
            for (int m = j + 1; m < W; m++) begin
                term = term & prop_i[m];
            end
            orsum = orsum | term;
        end
        grp_gen_o  = orsum;
        grp_prop_o = &prop_i;
    end

    always_comb begin
        if (!$isunknown({gen_i, prop_i, carry_i})) begin
            AST_UNIT_EXCL: assert (!(grp_gen_o && grp_prop_o)); // R4
            AST_UNIT_COUT: assert (carry_o[W] == (grp_gen_o | (grp_prop_o & carry_i))); // R5
            if (grp_prop_o) begin
                AST_UNIT_PASS: assert (carry_o[W] == carry_i); // R6
            end
        end
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int GRP_W = cla_pkg::GRP_W,
    parameter int N_GRP = cla_pkg::N_GRP
) (
    input  logic [GRP_W*N_GRP-1:0] op_a,
    input  logic [GRP_W*N_GRP-1:0] op_b,
    input  logic                   carry_in,
    output logic [GRP_W*N_GRP-1:0] sum,
    output logic                   carry_out,
    output logic                   grp_gen,
    output logic                   grp_prop
);
    localparam int DW = GRP_W * N_GRP;

    logic [DW-1:0]    bit_prop_w;
    logic [DW-1:0]    bit_gen_w;
    logic [DW-1:0]    bit_carry_w;
    logic [N_GRP-1:0] blk_gen_w;
    logic [N_GRP-1:0] blk_prop_w;
    logic [N_GRP:0]   blk_carry_w;

    cla_pfa_row #(.W(DW)) u_pfa (
        .a_i     (op_a),
        .b_i     (op_b),
        .carry_i (bit_carry_w),
        .prop_o  (bit_prop_w),
        .gen_o   (bit_gen_w),
        .sum_o   (sum)
    );

    for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
        logic [GRP_W:0] local_carry_w;

        cla_lookahead #(.W(GRP_W)) u_la (
            .gen_i      (bit_gen_w[gi*GRP_W +: GRP_W]),
            .prop_i     (bit_prop_w[gi*GRP_W +: GRP_W]),
            .carry_i    (blk_carry_w[gi]),
            .carry_o    (local_carry_w),
            .grp_gen_o  (blk_gen_w[gi]),
            .grp_prop_o (blk_prop_w[gi])
        );

        assign bit_carry_w[gi*GRP_W +: GRP_W] = local_carry_w[GRP_W-1:0];

        always_comb begin
            if (!$isunknown({op_a, op_b, carry_in})) begin
                // group carry-out seen by this unit must match the next level
                AST_GRP_BOUNDARY: assert (local_carry_w[GRP_W] == blk_carry_w[gi+1]); // R7
            end
        end
    end

    cla_lookahead #(.W(N_GRP)) u_la_top (
        .gen_i      (blk_gen_w),
        .prop_i     (blk_prop_w),
        .carry_i    (carry_in),
        .carry_o    (blk_carry_w),
        .grp_gen_o  (grp_gen),
        .grp_prop_o (grp_prop)
    );

    assign carry_out = blk_carry_w[N_GRP];

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            AST_SUM_EXACT: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{DW{1'b0}}, carry_in})); // R1
            AST_NO_BOTH: assert (!(grp_gen && grp_prop)); // R4
            AST_COUT_REL: assert (carry_out == (grp_gen | (grp_prop & carry_in))); // R5
        end
    end
endmodule

// File: tb/cla_adder16_bench.sv
module cla_adder16_bench;
    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out, grp_gen, grp_prop;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cla_adder16 u_cla_adder16 (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out),
        .grp_gen(grp_gen), .grp_prop(grp_prop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, op_a, op_b, carry_in, act, exp);
        end
    endtask

    // Drive after a rising edge, judge at the following falling edge.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
        int full;
        int pair;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = c;
        @(negedge clk);
        full = int'(a) + int'(b) + int'(c);
        pair = int'(a) + int'(b);
        check("R1", {15'b0, carry_out, sum}, full);
        check("R2", {31'b0, grp_gen}, {31'b0, pair >= 65536});
        check("R3", {31'b0, grp_prop}, {31'b0, pair == 65535});
        check("R4", {31'b0, grp_gen & grp_prop}, 32'd0);
        check("R5", {31'b0, carry_out}, {31'b0, (pair >= 65536) | ((pair == 65535) & c)});
    endtask

    initial begin
        @(negedge clk);
        check("R1 zero", {15'b0, carry_out, sum}, 32'd0);
        apply(16'hFFFF, 16'h0001, 1'b0);               // all-ones plus one
        check("R6 wrap", {15'b0, carry_out, sum}, 32'h10000);
        apply(16'hFFFF, 16'h0000, 1'b1);               // R6 carry_in through all groups
        check("R6 pass1", {31'b0, carry_out}, 32'd1);
        apply(16'hFFFF, 16'h0000, 1'b0);
        check("R6 pass0", {15'b0, carry_out, sum}, 32'h0FFFF);
        apply(16'hAAAA, 16'h5555, 1'b1);
        check("R6 alt", {15'b0, carry_out, sum}, 32'h10000);
        apply(16'hAAAA, 16'hAAAA, 1'b0);
        apply(16'h5555, 16'h5555, 1'b1);
        apply(16'h0FFF, 16'h0001, 1'b0);
        check("R7 b12", {15'b0, carry_out, sum}, 32'h01000);
        apply(16'h000F, 16'h0001, 1'b0);
        check("R7 b4", {16'b0, sum}, 32'h0010);
        apply(16'h00FF, 16'h0000, 1'b1);
        check("R7 b8", {16'b0, sum}, 32'h0100);
        apply(16'hFFF8, 16'h0008, 1'b1);               // generate in group 0 plus cin
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        apply(16'h8000, 16'h8000, 1'b0);
        // R8: same vector after different predecessors must agree
        apply(16'h1234, 16'hEDCB, 1'b1);
        apply(16'h0000, 16'h0000, 1'b0);
        apply(16'h1234, 16'hEDCB, 1'b1);
        check("R8 repeat", {15'b0, carry_out, sum}, 32'h10000);
        for (int i = 0; i < 600; i++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule